// File: doc/BRIEF.md
# Processor Mode and Exception Controller

This block keeps the processor's current status word and performs the register-level steps of taking and leaving an exception. Each exception mode has its own saved copy of the status word and its own link register. User and system modes share one link register and have no saved copy.

When an exception is taken, the block does four things in the same clock cycle:
- saves the live status word into the target mode's bank;
- drops out of the compact 16-bit instruction state;
- stores the supplied return address in the target mode's link register;
- issues a redirect to that exception's handler address.

A return command undoes this. It restores the saved copy of the current mode and redirects to that mode's link register value.

The surrounding core uses two write ports and one output:
- It loads new status words through a write port, for flag updates and explicit mode changes.
- It writes the active mode's link register through a second port.
- It reads the active link register from `lr_banked`.

Top module: `mode_exc_ctrl`

## Requirements
- R1: After reset the status word is 0x000000D3: supervisor mode, bits 7 and 6 set, bit 5 clear, flags zero. `redirect_valid` is low.
- R2: With no exception and no valid return, `psr_wr` loads `psr_wdata` into the status word on the next cycle and produces no redirect.
- R3: Taking an exception copies the status word as it stood before entry into the saved-status bank of the target mode.
- R4: On entry, bits 4:0 take the target mode and bit 5 is cleared. Every other bit is kept, except that interrupt entry also sets bit 7 and fast-interrupt entry sets bits 7 and 6. Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, monitor 10110, abort 10111, undefined 11011 and system 11111.
- R5: On entry, `ret_addr` is written to the target mode's link register, which then shows on `lr_banked`. `redirect_valid` is high for exactly one cycle.
- R6: Synchronous requests carry `exc_type`: 0 undefined → undefined mode; 1 supervisor call → supervisor mode; 2 prefetch abort → abort mode; 3 data abort → abort mode. The handler addresses, relative to `VEC_BASE`, are 0x04 undefined, 0x08 supervisor call, 0x0C prefetch abort, 0x10 data abort, 0x18 interrupt and 0x1C fast interrupt.
- R7: `irq_req` is accepted only while bit 7 is clear and `fiq_req` only while bit 6 is clear. A masked request changes nothing.
- R8: Fixed priority: a synchronous request beats the fast interrupt, which beats the interrupt.
- R9: In a mode with a saved-status bank, `ret_cmd` copies that bank into the status word and redirects to that mode's link register value.
- R10: In user or system mode, `ret_cmd` is ignored. The status word is unchanged and no redirect is issued.
- R11: When events coincide in one cycle, exception entry wins over return, and return wins over `psr_wr`. During entry, `lr_wr` is discarded.
- R12: `lr_wr` writes `lr_wdata` to the active mode's link register. User and system modes share one link register, separate from every exception mode's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_type | input | 2 | Synchronous exception kind (see R6) |
| irq_req | input | 1 | Interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| ret_addr | input | AW | Return address banked on entry |
| ret_cmd | input | 1 | Exception return command |
| psr_wr | input | 1 | Status word write strobe |
| psr_wdata | input | 32 | Status word write value |
| lr_wr | input | 1 | Active link register write strobe |
| lr_wdata | input | AW | Active link register write value |
| cpsr | output | 32 | Current status word |
| redirect_valid | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | AW | Redirect target |
| lr_banked | output | AW | Link register of the active mode |

## Verification
Every event is registered once. The status word, `redirect_valid` and `redirect_pc` change at the first rising edge after the stimulus is presented. `lr_banked` is a read of the bank selected by the new mode, so it shows the new value in that same cycle. The bench drives each stimulus for exactly one cycle from a falling edge and samples at the next falling edge. It then takes one more sample to confirm the redirect strobe has dropped. A full sweep covers every exception kind, three starting modes and both instruction states, each followed by a return that must restore the exact starting word.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int PSR_W   = 32;
    localparam int NBANK   = 7;
    localparam int BANK_W  = $clog2(NBANK);

    localparam int PSR_T   = 5;
    localparam int PSR_F   = 6;
    localparam int PSR_I   = 7;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_MON = 5'b10110;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    localparam logic [1:0] EXT_UND  = 2'd0;
    localparam logic [1:0] EXT_SVC  = 2'd1;
    localparam logic [1:0] EXT_PABT = 2'd2;
    localparam logic [1:0] EXT_DABT = 2'd3;

    typedef struct packed {
        logic       take;
        logic [4:0] mode;
        logic       set_i;
        logic       set_f;
        logic [4:0] vec_off;
    } entry_t;

    // Bank 0 is shared by user, system and any unassigned code; it has no saved status.
    function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
        case (m)
            MODE_FIQ: bank_of = BANK_W'(1);
            MODE_IRQ: bank_of = BANK_W'(2);
            MODE_SVC: bank_of = BANK_W'(3);
            MODE_ABT: bank_of = BANK_W'(4);
            MODE_UND: bank_of = BANK_W'(5);
            MODE_MON: bank_of = BANK_W'(6);
            default:  bank_of = BANK_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic       exc_req,
    input  logic [1:0] exc_type,
    input  logic       irq_req,
    input  logic       fiq_req,
    input  logic       mask_i,
    input  logic       mask_f,
    output entry_t     ent
);

    always_comb begin
        ent = '0;
        if (exc_req) begin
            ent.take = 1'b1;
            case (exc_type)
                EXT_UND:  begin ent.mode = MODE_UND; ent.vec_off = 5'h04; end
                EXT_SVC:  begin ent.mode = MODE_SVC; ent.vec_off = 5'h08; end
                EXT_PABT: begin ent.mode = MODE_ABT; ent.vec_off = 5'h0C; end
                default:  begin ent.mode = MODE_ABT; ent.vec_off = 5'h10; end
            endcase
        end else if (fiq_req && !mask_f) begin
            ent.take    = 1'b1;
            ent.mode    = MODE_FIQ;
            ent.set_i   = 1'b1;
            ent.set_f   = 1'b1;
            ent.vec_off = 5'h1C;
        end else if (irq_req && !mask_i) begin
            ent.take    = 1'b1;
            ent.mode    = MODE_IRQ;
            ent.set_i   = 1'b1;
            ent.vec_off = 5'h18;
        end
    end

endmodule

// File: rtl/bank_regs.sv
module bank_regs
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int NB = NBANK,
    parameter int PW = PSR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spsr_we,
    input  logic [BANK_W-1:0] spsr_widx,
    input  logic [PW-1:0]     spsr_wdata,
    input  logic              lr_we,
    input  logic [BANK_W-1:0] lr_widx,
    input  logic [AW-1:0]     lr_wdata,
    input  logic [BANK_W-1:0] ridx,
    output logic [PW-1:0]     spsr_rd,
    output logic [AW-1:0]     lr_rd
);

    logic [PW-1:0] spsr_arr [NB];
    logic [AW-1:0] lr_arr   [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [PW-1:0] spsr_d, spsr_q;
        logic [AW-1:0] lr_d, lr_q;

        always_comb begin
            spsr_d = spsr_q;
            lr_d   = lr_q;
            if (spsr_we && spsr_widx == BANK_W'(b)) spsr_d = spsr_wdata;
            if (lr_we && lr_widx == BANK_W'(b))     lr_d   = lr_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                spsr_q <= '0;
                lr_q   <= '0;
            end else begin
                spsr_q <= spsr_d;
                lr_q   <= lr_d;
            end
        end

        assign spsr_arr[b] = spsr_q;
        assign lr_arr[b]   = lr_q;
    end

    always_comb begin
        spsr_rd = '0;
        lr_rd   = '0;
        for (int b = 0; b < NB; b++) begin
            if (ridx == BANK_W'(b)) begin
                spsr_rd = spsr_arr[b];
                lr_rd   = lr_arr[b];
            end
        end
    end

endmodule

// File: rtl/mode_exc_ctrl.sv
module mode_exc_ctrl
    import exc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [1:0]       exc_type,
    input  logic             irq_req,
    input  logic             fiq_req,
    input  logic [AW-1:0]    ret_addr,
    input  logic             ret_cmd,
    input  logic             psr_wr,
    input  logic [PSR_W-1:0] psr_wdata,
    input  logic             lr_wr,
    input  logic [AW-1:0]    lr_wdata,
    output logic [PSR_W-1:0] cpsr,
    output logic             redirect_valid,
    output logic [AW-1:0]    redirect_pc,
    output logic [AW-1:0]    lr_banked
);

    localparam logic [PSR_W-1:0] PSR_RESET = PSR_W'(32'h0000_00D3);

    typedef struct packed {
        logic [PSR_W-1:0] psr;
        logic             rv;
        logic [AW-1:0]    pc;
    } state_t;

    state_t st_d, st_q;

    entry_t            ent;
    logic [BANK_W-1:0] cur_bank;
    logic              cur_has_spsr;
    logic              spsr_we, lr_we;
    logic [BANK_W-1:0] spsr_widx, lr_widx;
    logic [PSR_W-1:0]  spsr_wdata, spsr_rd;
    logic [AW-1:0]     lr_wval, lr_rd;

    exc_select u_sel (
        .exc_req  (exc_req),
        .exc_type (exc_type),
        .irq_req  (irq_req),
        .fiq_req  (fiq_req),
        .mask_i   (st_q.psr[PSR_I]),
        .mask_f   (st_q.psr[PSR_F]),
        .ent      (ent)
    );

    assign cur_bank     = bank_of(st_q.psr[4:0]);
    assign cur_has_spsr = (cur_bank != '0);

    bank_regs #(.AW(AW), .NB(NBANK), .PW(PSR_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .spsr_we    (spsr_we),
        .spsr_widx  (spsr_widx),
        .spsr_wdata (spsr_wdata),
        .lr_we      (lr_we),
        .lr_widx    (lr_widx),
        .lr_wdata   (lr_wval),
        .ridx       (cur_bank),
        .spsr_rd    (spsr_rd),
        .lr_rd      (lr_rd)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rv    = 1'b0;
        spsr_we    = 1'b0;
        spsr_widx  = bank_of(ent.mode);
        spsr_wdata = st_q.psr;
        lr_we      = 1'b0;
        lr_widx    = cur_bank;
        lr_wval    = lr_wdata;

        if (ent.take) begin
            spsr_we          = 1'b1;
            lr_we            = 1'b1;
            lr_widx          = bank_of(ent.mode);
            lr_wval          = ret_addr;
            st_d.psr[4:0]    = ent.mode;
            st_d.psr[PSR_T]  = 1'b0;
            if (ent.set_i) st_d.psr[PSR_I] = 1'b1;
            if (ent.set_f) st_d.psr[PSR_F] = 1'b1;
            st_d.rv          = 1'b1;
            st_d.pc          = VEC_BASE + {{(AW-5){1'b0}}, ent.vec_off};
        end else begin
            lr_we = lr_wr;
            if (ret_cmd && cur_has_spsr) begin
                st_d.psr = spsr_rd;
                st_d.rv  = 1'b1;
                st_d.pc  = lr_rd;
            end else if (psr_wr) begin
                st_d.psr = psr_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.psr <= PSR_RESET;
            st_q.rv  <= 1'b0;
            st_q.pc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpsr           = st_q.psr;
    assign redirect_valid = st_q.rv;
    assign redirect_pc    = st_q.pc;
    assign lr_banked      = lr_rd;

    assert_entry_thumb_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ent.take |=> (!cpsr[PSR_T] && redirect_valid));

    assert_fiq_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ent.take && ent.set_f) |=> (cpsr[PSR_I] && cpsr[PSR_F] && cpsr[4:0] == MODE_FIQ));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpsr[PSR_I] && !fiq_req && !exc_req && !ret_cmd && !psr_wr)
        |=> (!redirect_valid && $stable(cpsr)));

    assert_return_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cmd && !ent.take && cur_has_spsr)
        |=> (redirect_valid && redirect_pc == $past(lr_rd) && cpsr == $past(spsr_rd)));

    assert_return_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_cmd && !ent.take && !psr_wr && (cpsr[4:0] == MODE_USR || cpsr[4:0] == MODE_SYS))
        |=> (!redirect_valid && $stable(cpsr)));

    assert_redirect_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !ent.take && !ret_cmd) |=> !redirect_valid);

endmodule

// File: tb/tb_mode_exc_ctrl.sv
module tb_mode_exc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req, irq_req, fiq_req, ret_cmd, psr_wr, lr_wr;
    logic [1:0]  exc_type;
    logic [31:0] ret_addr, psr_wdata, lr_wdata;
    logic [31:0] cpsr, redirect_pc, lr_banked;
    logic        redirect_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mode_exc_ctrl #(.AW(32), .VEC_BASE(32'h0)) dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .irq_req(irq_req), .fiq_req(fiq_req), .ret_addr(ret_addr), .ret_cmd(ret_cmd),
        .psr_wr(psr_wr), .psr_wdata(psr_wdata), .lr_wr(lr_wr), .lr_wdata(lr_wdata),
        .cpsr(cpsr), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .lr_banked(lr_banked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle;
        exc_req = 0; irq_req = 0; fiq_req = 0; ret_cmd = 0; psr_wr = 0; lr_wr = 0;
    endtask

    task automatic set_psr(input logic [31:0] v);
        psr_wr = 1; psr_wdata = v;
        tick;
        psr_wr = 0;
    endtask

    function automatic logic [4:0] start_mode(input int i);
        case (i)
            0:       return 5'b10000;
            1:       return 5'b11111;
            default: return 5'b10011;
        endcase
    endfunction

    function automatic logic [4:0] tgt_mode(input int t);
        case (t)
            0:       return 5'b11011;
            1:       return 5'b10011;
            2, 3:    return 5'b10111;
            4:       return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] start, exp;
        logic [31:0] ra;
        idle;
        exc_type = 0; ret_addr = 0; psr_wdata = 0; lr_wdata = 0;
        rst_n = 0;
        @(negedge clk);
        tick; tick;
        chk("R1 reset psr", cpsr, 32'h0000_00D3);
        chk("R1 reset redirect", {31'b0, redirect_valid}, 32'h0);
        rst_n = 1;
        tick;

        set_psr(32'hA000_0010);
        chk("R2 psr write", cpsr, 32'hA000_0010);
        chk("R2 no redirect", {31'b0, redirect_valid}, 32'h0);

        // Sweep: every exception kind, three starting modes, both instruction states
        for (int t = 0; t < 6; t++) begin
            for (int mi = 0; mi < 3; mi++) begin
                for (int tb = 0; tb < 2; tb++) begin
                    start = {4'(t * 6 + mi * 2 + tb), 20'h0, 2'b00, 1'(tb), start_mode(mi)};
                    set_psr(start);
                    chk("R2 start psr", cpsr, start);
                    ra = 32'h1000_0000 + 32'(t << 8) + 32'(mi << 4) + 32'(tb * 4);
                    ret_addr = ra;
                    if (t < 4) begin exc_req = 1; exc_type = 2'(t); end
                    else if (t == 4) irq_req = 1;
                    else fiq_req = 1;
                    tick;
                    idle;
                    exp = start;
                    exp[4:0] = tgt_mode(t);
                    exp[5] = 1'b0;
                    if (t >= 4) exp[7] = 1'b1;
                    if (t == 5) exp[6] = 1'b1;
                    chk("R4 entry psr", cpsr, exp);
                    chk("R5 redirect on entry", {31'b0, redirect_valid}, 32'h1);
                    case (t)
                        0: chk("R6 vector", redirect_pc, 32'h04);
                        1: chk("R6 vector", redirect_pc, 32'h08);
                        2: chk("R6 vector", redirect_pc, 32'h0C);
                        3: chk("R6 vector", redirect_pc, 32'h10);
                        4: chk("R6 vector", redirect_pc, 32'h18);
                        default: chk("R6 vector", redirect_pc, 32'h1C);
                    endcase
                    chk("R5 banked lr", lr_banked, ra);
                    tick;
                    chk("R5 single pulse", {31'b0, redirect_valid}, 32'h0);
                    ret_cmd = 1;
                    tick;
                    ret_cmd = 0;
                    chk("R3 R9 restored psr", cpsr, start);
                    chk("R9 return redirect", {31'b0, redirect_valid}, 32'h1);
                    chk("R9 return pc", redirect_pc, ra);
                end
            end
        end

        // R7 masking
        set_psr(32'h0000_0090);
        irq_req = 1; tick; idle;
        chk("R7 irq masked psr", cpsr, 32'h0000_0090);
        chk("R7 irq masked redirect", {31'b0, redirect_valid}, 32'h0);
        set_psr(32'h0000_0050);
        fiq_req = 1; tick; idle;
        chk("R7 fiq masked psr", cpsr, 32'h0000_0050);
        chk("R7 fiq masked redirect", {31'b0, redirect_valid}, 32'h0);
        set_psr(32'h0000_0050);
        fiq_req = 1; irq_req = 1; ret_addr = 32'h2000_0000; tick; idle;
        chk("R7 R8 irq under fiq mask", cpsr, 32'h0000_00D2);
        chk("R7 R8 irq vector", redirect_pc, 32'h18);

        // R8 priority
        set_psr(32'h0000_0010);
        exc_req = 1; exc_type = 2'd1; fiq_req = 1; irq_req = 1; tick; idle;
        chk("R8 sync wins psr", cpsr, 32'h0000_0013);
        chk("R8 sync wins vector", redirect_pc, 32'h08);
        set_psr(32'h0000_0010);
        fiq_req = 1; irq_req = 1; tick; idle;
        chk("R8 fiq wins psr", cpsr, 32'h0000_00D1);
        chk("R8 fiq wins vector", redirect_pc, 32'h1C);

        // R10 ignored returns
        set_psr(32'h0000_0010);
        ret_cmd = 1; tick; idle;
        chk("R10 user return psr", cpsr, 32'h0000_0010);
        chk("R10 user return redirect", {31'b0, redirect_valid}, 32'h0);
        set_psr(32'h0000_001F);
        ret_cmd = 1; tick; idle;
        chk("R10 system return psr", cpsr, 32'h0000_001F);
        chk("R10 system return redirect", {31'b0, redirect_valid}, 32'h0);

        // R12 link register sharing
        set_psr(32'h0000_0010);
        lr_wr = 1; lr_wdata = 32'hCAFE_0000; tick; idle;
        chk("R12 user lr write", lr_banked, 32'hCAFE_0000);
        set_psr(32'h0000_001F);
        chk("R12 system shares lr", lr_banked, 32'hCAFE_0000);
        set_psr(32'h0000_0013);
        lr_wr = 1; lr_wdata = 32'h0000_5555; tick; idle;
        chk("R12 supervisor lr write", lr_banked, 32'h0000_5555);
        set_psr(32'h0000_0010);
        chk("R12 user lr untouched", lr_banked, 32'hCAFE_0000);

        // R11 collisions
        exc_req = 1; exc_type = 2'd0; ret_cmd = 1; psr_wr = 1; psr_wdata = 32'h0000_001F;
        lr_wr = 1; lr_wdata = 32'h0000_1234; ret_addr = 32'h3000_0000;
        tick; idle;
        chk("R11 entry beats others psr", cpsr, 32'h0000_001B);
        chk("R11 entry vector", redirect_pc, 32'h04);
        chk("R11 entry lr", lr_banked, 32'h3000_0000);
        ret_cmd = 1; psr_wr = 1; psr_wdata = 32'h0000_0013;
        tick; idle;
        chk("R11 return beats write psr", cpsr, 32'h0000_0010);
        chk("R11 return pc", redirect_pc, 32'h3000_0000);
        chk("R11 lr write dropped on entry", lr_banked, 32'hCAFE_0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule